// File: doc/BRIEF.md
# Interrupt State Table Command Engine

This block accepts configuration commands from a processor-side interface and applies each one to a single entry of an on-chip interrupt state table. The table has one bank per interrupt domain. Each bank holds a 32-bit entry for every interrupt ID in range.

A command names one of five operations: priority, enable, pending, handling mode or target affinity. It also carries an interrupt ID, a 16-bit value, a routing-mode bit, a domain, an interrupt type and a virtual flag. For every accepted command, the engine reads the addressed entry, replaces only the field the command selects, and writes the entry back.

Illegal commands are dropped without touching any entry. These are commands that are virtual, that name a type other than the one served, that carry an out-of-range ID, or that select an invalid or absent domain. A dropped command sets a sticky error flag. Nothing is reported back to the command issuer. A debug read port exposes any entry.

Top module: `ist_cmd_engine`

## Requirements
- R1: After reset, every entry of every bank reads zero, `err_flag` is low and `cmd_ready` is high.
- R2: Opcode 0 writes `cmd_value[7:0]` into entry bits 15:8 (priority). All other entry bits are unchanged.
- R3: Opcode 1 writes `cmd_value[0]` into entry bit 1 (enable). Opcode 2 writes `cmd_value[0]` into entry bit 0 (pending). All other bits are unchanged.
- R4: Opcode 3 writes `cmd_value[0]` into entry bit 2 (handling mode: 0 edge, 1 level). All other bits are unchanged.
- R5: Opcode 4 writes `cmd_value[15:0]` into entry bits 31:16 (target affinity). It behaves the same for `cmd_route` 0 (targeted) and 1 (one-of-many). Entry bit 3 always stays 0.
- R6: A command with `cmd_virtual` high changes no entry and sets `err_flag`.
- R7: A command whose `cmd_type` is not 2 (the only served type) changes no entry and sets `err_flag`.
- R8: A command whose ID has any bit set at or above position TBL_ID_W changes no entry and sets `err_flag`.
- R9: A command whose domain has its `dom_valid` bit low, or whose domain index is NUM_DOM or higher, changes no entry and sets `err_flag`.
- R10: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is then low for exactly two cycles. The write is visible on the debug port when `cmd_ready` returns high, so commands held back-to-back apply in order.
- R11: `err_flag` stays high until reset. Legal commands never raise it.
- R12: Opcodes 5, 6 and 7 change no entry and set `err_flag`.
- R13: A command changes only the entry at its own domain and ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 3 | Operation: 0 priority, 1 enable, 2 pending, 3 handling, 4 target |
| cmd_id | input | CMD_ID_W | Interrupt ID |
| cmd_value | input | 16 | New field value |
| cmd_route | input | 1 | Routing mode of a target command (0 targeted, 1 one-of-many) |
| cmd_domain | input | DOM_W | Domain selector |
| cmd_type | input | 2 | Interrupt type; 2 is served |
| cmd_virtual | input | 1 | Virtual-interrupt flag |
| dom_valid | input | NUM_DOM | Per-domain table-valid bits |
| err_flag | output | 1 | Sticky flag for dropped commands |
| dbg_domain | input | DOM_W | Debug read domain |
| dbg_id | input | TBL_ID_W | Debug read index |
| dbg_data | output | 32 | Debug read entry (0 for an absent domain) |

## Verification
The bench builds the engine with NUM_DOM=3, TBL_ID_W=3 and CMD_ID_W=5. That gives 24 entries, few enough to visit every domain, index and opcode twice with two value patterns. It also leaves a 2-bit domain code (3) that names no bank, so the absent-domain rule can be reached. With a 5-bit ID, an out-of-range ID can alias an in-range index in its low bits, which shows whether the range check really blocks the write.

// File: rtl/ist_pkg.sv
package ist_pkg;

    localparam int ENTRY_W = 32;
    localparam int VAL_W   = 16;
    localparam int PRIO_W  = 8;

    localparam logic [2:0] OP_PRIO   = 3'd0;
    localparam logic [2:0] OP_ENABLE = 3'd1;
    localparam logic [2:0] OP_PEND   = 3'd2;
    localparam logic [2:0] OP_HMODE  = 3'd3;
    localparam logic [2:0] OP_TARGET = 3'd4;

    localparam logic [1:0] ITYPE_SERVED = 2'd2;

    // One-of-many routing is absent: the stored routing bit is forced low.
    localparam logic ROUTE_MANY_SUPPORTED = 1'b0;

    typedef struct packed {
        logic [VAL_W-1:0]  aff;
        logic [PRIO_W-1:0] prio;
        logic [3:0]        rsvd;
        logic              route;
        logic              hmode;
        logic              enable;
        logic              pend;
    } ist_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } ist_state_e;

endpackage

// File: rtl/ist_cmd_decode.sv
module ist_cmd_decode
    import ist_pkg::*;
#(
    parameter int NUM_DOM  = 4,
    parameter int TBL_ID_W = 6,
    parameter int CMD_ID_W = 16,
    parameter int DOM_W    = 2
) (
    input  logic [2:0]          op,
    input  logic [CMD_ID_W-1:0] id,
    input  logic [DOM_W-1:0]    dom,
    input  logic [1:0]          itype,
    input  logic                virt,
    input  logic [NUM_DOM-1:0]  dom_valid,
    output logic                legal,
    output logic [TBL_ID_W-1:0] addr
);

    logic op_ok;
    logic type_ok;
    logic id_ok;
    logic dom_ok;

    assign op_ok   = (op <= OP_TARGET);
    assign type_ok = (itype == ITYPE_SERVED);
    assign id_ok   = (id[CMD_ID_W-1:TBL_ID_W] == '0);
    assign addr    = id[TBL_ID_W-1:0];

    always_comb begin
        dom_ok = 1'b0;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (dom == DOM_W'(d) && dom_valid[d]) begin
                dom_ok = 1'b1;
            end
        end
    end

    assign legal = op_ok && type_ok && id_ok && dom_ok && !virt;

endmodule

// File: rtl/ist_field_merge.sv
module ist_field_merge
    import ist_pkg::*;
(
    input  ist_entry_t       cur,
    input  logic [2:0]       op,
    input  logic [VAL_W-1:0] val,
    input  logic             route,
    output ist_entry_t       nxt
);

    always_comb begin
        nxt = cur;
        case (op)
            OP_PRIO:   nxt.prio   = val[PRIO_W-1:0];
            OP_ENABLE: nxt.enable = val[0];
            OP_PEND:   nxt.pend   = val[0];
            OP_HMODE:  nxt.hmode  = val[0];
            OP_TARGET: begin
                nxt.aff   = val;
                nxt.route = ROUTE_MANY_SUPPORTED & route;
            end
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/ist_bank.sv
module ist_bank
    import ist_pkg::*;
#(
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  ist_entry_t    wdata,
    input  logic [AW-1:0] raddr_a,
    output ist_entry_t    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output ist_entry_t    rdata_b
);

    ist_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/ist_cmd_engine.sv
module ist_cmd_engine
    import ist_pkg::*;
#(
    parameter int NUM_DOM  = 4,
    parameter int TBL_ID_W = 6,
    parameter int CMD_ID_W = 16,
    localparam int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [2:0]          cmd_op,
    input  logic [CMD_ID_W-1:0] cmd_id,
    input  logic [VAL_W-1:0]    cmd_value,
    input  logic                cmd_route,
    input  logic [DOM_W-1:0]    cmd_domain,
    input  logic [1:0]          cmd_type,
    input  logic                cmd_virtual,
    input  logic [NUM_DOM-1:0]  dom_valid,
    output logic                err_flag,
    input  logic [DOM_W-1:0]    dbg_domain,
    input  logic [TBL_ID_W-1:0] dbg_id,
    output logic [ENTRY_W-1:0]  dbg_data
);

    ist_state_e          state;
    logic [2:0]          q_op;
    logic [TBL_ID_W-1:0] q_addr;
    logic [VAL_W-1:0]    q_val;
    logic                q_route;
    logic [DOM_W-1:0]    q_dom;
    logic                q_legal;
    ist_entry_t          entry_q;

    logic                dec_legal;
    logic [TBL_ID_W-1:0] dec_addr;
    logic                accept;
    logic                wr_en;
    ist_entry_t          merged;
    ist_entry_t          rd_a [NUM_DOM];
    ist_entry_t          rd_b [NUM_DOM];
    ist_entry_t          rd_sel;
    ist_entry_t          dbg_sel;

    ist_cmd_decode #(
        .NUM_DOM (NUM_DOM),
        .TBL_ID_W(TBL_ID_W),
        .CMD_ID_W(CMD_ID_W),
        .DOM_W   (DOM_W)
    ) u_decode (
        .op       (cmd_op),
        .id       (cmd_id),
        .dom      (cmd_domain),
        .itype    (cmd_type),
        .virt     (cmd_virtual),
        .dom_valid(dom_valid),
        .legal    (dec_legal),
        .addr     (dec_addr)
    );

    assign cmd_ready = (state == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign wr_en     = (state == ST_WRITE) && q_legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            err_flag <= 1'b0;
            q_op     <= '0;
            q_addr   <= '0;
            q_val    <= '0;
            q_route  <= 1'b0;
            q_dom    <= '0;
            q_legal  <= 1'b0;
            entry_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        q_op    <= cmd_op;
                        q_addr  <= dec_addr;
                        q_val   <= cmd_value;
                        q_route <= cmd_route;
                        q_dom   <= cmd_domain;
                        q_legal <= dec_legal;
                        if (!dec_legal) begin
                            err_flag <= 1'b1;
                        end
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    entry_q <= rd_sel;
                    state   <= ST_WRITE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    ist_field_merge u_merge (
        .cur  (entry_q),
        .op   (q_op),
        .val  (q_val),
        .route(q_route),
        .nxt  (merged)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_bank
        ist_bank #(.AW(TBL_ID_W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .we     (wr_en && (q_dom == DOM_W'(d))),
            .waddr  (q_addr),
            .wdata  (merged),
            .raddr_a(q_addr),
            .rdata_a(rd_a[d]),
            .raddr_b(dbg_id),
            .rdata_b(rd_b[d])
        );
    end

    always_comb begin
        rd_sel  = '0;
        dbg_sel = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (q_dom == DOM_W'(d)) begin
                rd_sel = rd_a[d];
            end
            if (dbg_domain == DOM_W'(d)) begin
                dbg_sel = rd_b[d];
            end
        end
    end

    assign dbg_data = dbg_sel;

endmodule

// File: rtl/ist_cmd_engine_sva.sv
module ist_cmd_engine_sva #(
    parameter int NUM_DOM  = 4,
    parameter int TBL_ID_W = 6,
    parameter int CMD_ID_W = 16,
    localparam int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [2:0]          cmd_op,
    input logic [CMD_ID_W-1:0] cmd_id,
    input logic [1:0]          cmd_type,
    input logic                cmd_virtual,
    input logic                err_flag,
    input logic [31:0]         dbg_data
);

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cmd_ready && !err_flag));

    // R10
    busy_first_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> !cmd_ready);

    // R10
    busy_second_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> ##1 !cmd_ready);

    // R10
    ready_back_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> ##2 cmd_ready);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R6
    virt_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_virtual) |=> err_flag);

    // R7
    type_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_type != 2'd2) |=> err_flag);

    // R8
    id_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && (cmd_id >> TBL_ID_W) != '0) |=> err_flag);

    // R12
    op_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op > 3'd4) |=> err_flag);

    // R5
    route_low_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_data[3] == 1'b0);

endmodule

bind ist_cmd_engine ist_cmd_engine_sva #(
    .NUM_DOM (NUM_DOM),
    .TBL_ID_W(TBL_ID_W),
    .CMD_ID_W(CMD_ID_W)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_id     (cmd_id),
    .cmd_type   (cmd_type),
    .cmd_virtual(cmd_virtual),
    .err_flag   (err_flag),
    .dbg_data   (dbg_data)
);

// File: tb/tb_ist_cmd_engine.sv
module tb_ist_cmd_engine;

    localparam int ND  = 3;
    localparam int TW  = 3;
    localparam int CW  = 5;
    localparam int NE  = 1 << TW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [CW-1:0] cmd_id = '0;
    logic [15:0]   cmd_value = '0;
    logic          cmd_route = 1'b0;
    logic [1:0]    cmd_domain = '0;
    logic [1:0]    cmd_type = 2'd2;
    logic          cmd_virtual = 1'b0;
    logic [ND-1:0] dom_valid = '1;
    logic          err_flag;
    logic [1:0]    dbg_domain = '0;
    logic [TW-1:0] dbg_id = '0;
    logic [31:0]   dbg_data;

    logic [31:0]   model [ND][NE];
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;

    ist_cmd_engine #(.NUM_DOM(ND), .TBL_ID_W(TW), .CMD_ID_W(CW)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_value(cmd_value),
        .cmd_route(cmd_route), .cmd_domain(cmd_domain), .cmd_type(cmd_type),
        .cmd_virtual(cmd_virtual), .dom_valid(dom_valid), .err_flag(err_flag),
        .dbg_domain(dbg_domain), .dbg_id(dbg_id), .dbg_data(dbg_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input int d, input int i, output logic [31:0] v);
        dbg_domain = 2'(d);
        dbg_id     = TW'(i);
        #1;
        v = dbg_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int d = 0; d < ND; d++)
            for (int i = 0; i < NE; i++)
                model[d][i] = '0;
    endtask

    // Drive one command at a negedge while idle; checks the busy window (R10).
    task automatic send(input logic [2:0] op, input int id, input logic [15:0] val,
                        input logic route, input int dom, input logic [1:0] typ,
                        input logic virt);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_id = CW'(id); cmd_value = val; cmd_route = route;
        cmd_domain = 2'(dom); cmd_type = typ; cmd_virtual = virt;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 busy1", {31'd0, cmd_ready}, 32'd0);
        @(negedge clk);
        check("R10 busy2", {31'd0, cmd_ready}, 32'd0);
        @(negedge clk);
        check("R10 ready back", {31'd0, cmd_ready}, 32'd1);
    endtask

    function automatic logic [31:0] expect_of(input logic [31:0] old, input int op,
                                              input logic [15:0] val);
        case (op)
            0: return (old & ~32'h0000FF00) | (32'(val & 16'hFF) * 256);
            1: return (old & ~32'h2) | (32'(val & 16'h1) * 2);
            2: return (old & ~32'h1) | 32'(val & 16'h1);
            3: return (old & ~32'h4) | (32'(val & 16'h1) * 4);
            4: return (old & 32'h0000FFFF) | (32'(val) * 65536);
            default: return old;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0: return "R2 priority";
            1: return "R3 enable";
            2: return "R3 pending";
            3: return "R4 handling";
            default: return "R5 target";
        endcase
    endfunction

    task automatic sweep_all(input string req);
        logic [31:0] v;
        for (int d = 0; d < ND; d++)
            for (int i = 0; i < NE; i++) begin
                peek(d, i, v);
                check(req, v, model[d][i]);
            end
    endtask

    // Preload entry (d,i), apply an illegal command, check nothing moved.
    task automatic reject_case(input string req, input logic [2:0] op, input int id,
                               input int dom, input logic [1:0] typ, input logic virt,
                               input int victim_dom, input int victim_id);
        logic [31:0] v;
        do_reset();
        dom_valid = '1;
        send(3'd0, victim_id, 16'h5A, 1'b0, victim_dom, 2'd2, 1'b0);
        model[victim_dom][victim_id] = expect_of(32'd0, 0, 16'h5A);
        send(3'd4, victim_id, 16'hBEEF, 1'b0, victim_dom, 2'd2, 1'b0);
        model[victim_dom][victim_id] = expect_of(model[victim_dom][victim_id], 4, 16'hBEEF);
        check({req, " legal preload no error"}, {31'd0, err_flag}, 32'd0);
        if (req == "R9 invalid domain") dom_valid[dom] = 1'b0;
        send(op, id, 16'h1234, 1'b1, dom, typ, virt);
        sweep_all({req, " table unchanged"});
        check({req, " error flag"}, {31'd0, err_flag}, 32'd1);
        dom_valid = '1;
        send(3'd1, victim_id, 16'h1, 1'b0, victim_dom, 2'd2, 1'b0);
        model[victim_dom][victim_id] = expect_of(model[victim_dom][victim_id], 1, 16'h1);
        peek(victim_dom, victim_id, v);
        check("R11 legal after drop applies", v, model[victim_dom][victim_id]);
        check("R11 error stays set", {31'd0, err_flag}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [15:0] val;
        do_reset();

        // R1: reset state
        check("R1 ready after reset", {31'd0, cmd_ready}, 32'd1);
        check("R1 error clear after reset", {31'd0, err_flag}, 32'd0);
        sweep_all("R1 entries zero");

        // R2..R5, R13: every domain, index and opcode, two value patterns
        for (int pass = 0; pass < 2; pass++)
            for (int d = 0; d < ND; d++)
                for (int i = 0; i < NE; i++)
                    for (int op = 0; op < 5; op++) begin
                        val = 16'((d * 37 + i * 11 + op * 5 + 3 + pass * 1001) * 97);
                        send(3'(op), i, val, 1'(i + pass), d, 2'd2, 1'b0);
                        model[d][i] = expect_of(model[d][i], op, val);
                        peek(d, i, v);
                        check(tag_of(op), v, model[d][i]);
                    end
        sweep_all("R13 only addressed entry changed");
        check("R11 legal commands leave error low", {31'd0, err_flag}, 32'd0);

        // R5: one-of-many request behaves as targeted
        send(3'd4, 2, 16'hA5C3, 1'b1, 1, 2'd2, 1'b0);
        model[1][2] = expect_of(model[1][2], 4, 16'hA5C3);
        peek(1, 2, v);
        check("R5 route=1 stores affinity, bit3 low", v, model[1][2]);

        // R10: held-valid burst to one ID, applied in order
        begin : burst
            logic [2:0]  ops  [3] = '{3'd0, 3'd0, 3'd2};
            logic [15:0] vals [3] = '{16'h11, 16'h22, 16'h1};
            for (int k = 0; k < 3; k++) begin
                cmd_op = ops[k]; cmd_id = CW'(6); cmd_value = vals[k];
                cmd_route = 1'b0; cmd_domain = 2'd0; cmd_type = 2'd2; cmd_virtual = 1'b0;
                cmd_valid = 1'b1;
                while (!cmd_ready) @(negedge clk);
                @(negedge clk);
                model[0][6] = expect_of(model[0][6], int'(ops[k]), vals[k]);
            end
            cmd_valid = 1'b0;
            while (!cmd_ready) @(negedge clk);
            peek(0, 6, v);
            check("R10 burst ordered result", v, model[0][6]);
        end

        // R1: reset clears a filled table
        do_reset();
        sweep_all("R1 entries zero after refill");
        check("R1 error clear", {31'd0, err_flag}, 32'd0);

        // Drop rules
        reject_case("R6 virtual", 3'd0, 5, 0, 2'd2, 1'b1, 0, 5);
        reject_case("R7 type 3", 3'd0, 5, 0, 2'd3, 1'b0, 0, 5);
        reject_case("R7 type 0", 3'd4, 5, 0, 2'd0, 1'b0, 0, 5);
        reject_case("R8 id alias 13", 3'd0, 13, 0, 2'd2, 1'b0, 0, 5);
        reject_case("R8 id 31", 3'd4, 31, 2, 2'd2, 1'b0, 2, 7);
        reject_case("R9 invalid domain", 3'd0, 5, 1, 2'd2, 1'b0, 1, 5);
        reject_case("R9 absent domain 3", 3'd0, 5, 3, 2'd2, 1'b0, 1, 5);
        for (int op = 5; op < 8; op++)
            reject_case("R12 undefined opcode", 3'(op), 5, 0, 2'd2, 1'b0, 0, 5);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule